// File: doc/BRIEF.md
# Chained Timer Counter

This block holds two timer channels that software joins into one wide free-running count. Channel 0 counts rising edges of a slow clock input. In waveform mode it drives an internal compare output. That output can be set, cleared or toggled when the counter matches either of two compare registers. A block-level routing field can feed this output to channel 1 as its external clock. Channel 1 then counts channel-0 epochs, and the two counter values together form a count of twice the counter width.

A simple register bus gives software access to the block. Writes take effect at the clock edge. Reads are combinational in the cycle that `bus_rd` is high. Each channel runs a three-state control machine:

- `CH_OFF`: the clock is disabled and the counter holds.
- `CH_ARMED`: the clock is enabled and the channel waits for a trigger.
- `CH_RUN`: the channel counts.

The machine moves as follows:

- `CH_OFF` goes to `CH_ARMED` on an enable command.
- `CH_OFF` goes to `CH_RUN` on an enable and a trigger in the same write.
- `CH_ARMED` goes to `CH_RUN` on a trigger.
- `CH_ARMED` and `CH_RUN` go to `CH_OFF` on a disable command.
- `CH_RUN` restarts from zero on a trigger and stays in `CH_RUN`.

A block-wide sync command triggers every enabled channel in the same cycle. A keyed protection register can freeze the configuration registers. An overflow flag per channel, with a mask, drives one interrupt line.

Top module: `tc_cascade`

## Requirements
- R1: After reset every readable register and counter is 0 and `irq` is low. Channel control (offset 0x00) bit 0 is the enable command and bit 1 is the disable command; disable wins if both are set. The counter holds its value in every state except `CH_RUN`.
- R2: A trigger (control bit 2, or the sync command) has two effects. It clears the counter to 0 and moves the channel to `CH_RUN`. It also drives the compare output low. A trigger is ignored in `CH_OFF` unless the same write also carries the enable command.
- R3: Mode bits 2:0 select the count source: 4 is the `slow_clk_in` pin, 6 is the external clock XC1, and any other value gives no clock. The source passes through a two-stage synchroniser. In `CH_RUN` the counter adds one on each rising edge of the source and wraps from all-ones to 0.
- R4: A counter wrap sets status bit 0 (offset 0x20). A read of the status register returns the flag and clears it. A wrap in the same cycle as the read keeps the flag set.
- R5: A write of bit 0 to offset 0x24 sets the channel's interrupt mask, and a write of bit 0 to offset 0x28 clears it. `irq` is high when any channel has both its flag and its mask set.
- R6: Mode bit 15 enables the compare output. On each count step the action in bits 17:16 is applied when the new count equals RA (offset 0x14). The action in bits 19:18 is applied when the new count equals RC (offset 0x1C), and it is applied after the RA action. Action codes are 0 none, 1 set, 2 clear, 3 toggle.
- R7: Bits 3:2 of the block routing register (0xC4) select channel 1's XC1. The value 2 routes channel 0's compare output; any other value holds XC1 low.
- R8: A write with bit 0 set to address 0xC0 triggers all channels that are not in `CH_OFF` in the same cycle.
- R9: A write to 0xE4 with bits 31:8 equal to 0x54494D loads protection from bit 0; other writes to 0xE4 are ignored, and a read of 0xE4 returns the protection bit in bit 0. While protection is on, writes to mode, RA, RB and RC (0x04, 0x14, 0x18, 0x1C) are ignored.
- R10: Channel k's registers sit at k*0x40 plus the offset, and the counter value reads at offset 0x10. Software reads channel 1, then channel 0, then channel 1 again, and retries until the two channel-1 reads match. With RA=0, RC at half range, set on RA and clear on RC, the counter value of channel 1 times 2^width plus that of channel 0 equals the number of slow-clock edges since the sync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slow_clk_in | input | 1 | Slow count clock, asynchronous to `clk` |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (clears status on read) |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while `bus_rd` is high |
| irq | output | 1 | Masked overflow interrupt |

## Verification
A channel machine stuck in the wrong state shows at the counter value port within one slow-clock period. A counter that moves while disabled, or that stays still after a trigger, reveals the fault. A wrong compare output state does not appear on a pin. It shows as a channel-1 count that is off by one, or that lags, at the next compare match. That can take up to a full channel-0 epoch, so the bench runs channel 0 through several complete wraps. A protection bit or mask in the wrong state shows on the next register read-back or at the next overflow on `irq`.

// File: rtl/tc_pkg.sv
package tc_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        CH_OFF   = 2'd0,
        CH_ARMED = 2'd1,
        CH_RUN   = 2'd2
    } ch_state_e;

    typedef struct packed {
        logic [1:0] rc_act;
        logic [1:0] ra_act;
        logic       wave;
        logic [2:0] src;
    } ch_mode_t;

    // per-channel offsets (low six address bits)
    localparam logic [5:0] OFS_CTRL = 6'h00;
    localparam logic [5:0] OFS_MODE = 6'h04;
    localparam logic [5:0] OFS_CV   = 6'h10;
    localparam logic [5:0] OFS_RA   = 6'h14;
    localparam logic [5:0] OFS_RB   = 6'h18;
    localparam logic [5:0] OFS_RC   = 6'h1C;
    localparam logic [5:0] OFS_SR   = 6'h20;
    localparam logic [5:0] OFS_IEN  = 6'h24;
    localparam logic [5:0] OFS_IDIS = 6'h28;

    // block-level addresses
    localparam logic [7:0] ADR_SYNC  = 8'hC0;
    localparam logic [7:0] ADR_XMUX  = 8'hC4;
    localparam logic [7:0] ADR_WPROT = 8'hE4;

    localparam logic [23:0] WP_KEY  = 24'h54494D;
    localparam logic [2:0]  SRC_SLOW = 3'd4;
    localparam logic [2:0]  SRC_XC1  = 3'd6;
    localparam logic [1:0]  XC1_FROM_CH0 = 2'd2;

    function automatic logic pin_action(input logic cur, input logic [1:0] act);
        logic r;
        unique case (act)
            2'd1:    r = 1'b1;
            2'd2:    r = 1'b0;
            2'd3:    r = ~cur;
            default: r = cur;
        endcase
        return r;
    endfunction

    function automatic logic [31:0] mode_word(input ch_mode_t m);
        logic [31:0] w;
        w        = '0;
        w[2:0]   = m.src;
        w[15]    = m.wave;
        w[17:16] = m.ra_act;
        w[19:18] = m.rc_act;
        return w;
    endfunction

endpackage

// File: rtl/tc_edge_sync.sv
module tc_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_in,
    output logic rise
);

    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              held;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= lvl_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], lvl_in};
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) held <= 1'b0;
        else        held <= chain[LAST];
    end

    assign rise = chain[LAST] & ~held;

endmodule

// File: rtl/tc_channel.sv
module tc_channel
    import tc_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             src_slow,
    input  logic             src_xc1,
    input  logic             ctrl_wr,
    input  logic [2:0]       ctrl_bits,
    input  logic             sync_trg,
    input  logic             mode_wr,
    input  logic             ra_wr,
    input  logic             rb_wr,
    input  logic             rc_wr,
    input  logic             ien_wr,
    input  logic             idis_wr,
    input  logic             sr_rd,
    input  logic [31:0]      wdata,
    output logic [CNT_W-1:0] cnt_o,
    output logic [CNT_W-1:0] ra_o,
    output logic [CNT_W-1:0] rb_o,
    output logic [CNT_W-1:0] rc_o,
    output ch_mode_t         mode_o,
    output logic             ovf_o,
    output logic             mask_o,
    output logic             wave_o,
    output logic             irq_o,
    output logic             off_o,
    output logic             run_o
);

    ch_state_e st_q, st_d;

    logic en_cmd, dis_cmd, trg_cmd, restart;
    logic src_lvl, tick, step;
    logic [CNT_W-1:0] cnt_q, cnt_inc, ra_q, rb_q, rc_q;
    ch_mode_t mode_q;
    logic wave_q, wave_d, ovf_q, mask_q;

    assign en_cmd  = ctrl_wr & ctrl_bits[0];
    assign dis_cmd = ctrl_wr & ctrl_bits[1];
    assign trg_cmd = (ctrl_wr & ctrl_bits[2]) | sync_trg;

    // next-state logic of the channel control machine
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            CH_OFF: begin
                if (en_cmd && !dis_cmd) st_d = trg_cmd ? CH_RUN : CH_ARMED;
            end
            CH_ARMED: begin
                if (dis_cmd)      st_d = CH_OFF;
                else if (trg_cmd) st_d = CH_RUN;
            end
            CH_RUN: begin
                if (dis_cmd) st_d = CH_OFF;
            end
            default: st_d = CH_OFF;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= CH_OFF;
        else        st_q <= st_d;
    end

    assign restart = trg_cmd && (st_d == CH_RUN);

    always_comb begin
        if (mode_q.src == SRC_SLOW)     src_lvl = src_slow;
        else if (mode_q.src == SRC_XC1) src_lvl = src_xc1;
        else                            src_lvl = 1'b0;
    end

    tc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_in (src_lvl),
        .rise   (tick)
    );

    assign step    = (st_q == CH_RUN) && tick && !restart && !dis_cmd;
    assign cnt_inc = cnt_q + 1'b1;

    always_comb begin
        wave_d = wave_q;
        if (cnt_inc == ra_q) wave_d = pin_action(wave_d, mode_q.ra_act);
        if (cnt_inc == rc_q) wave_d = pin_action(wave_d, mode_q.rc_act);
    end

    // outputs and datapath driven by the machine
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            wave_q <= 1'b0;
            ra_q   <= '0;
            rb_q   <= '0;
            rc_q   <= '0;
            mode_q <= '0;
            ovf_q  <= 1'b0;
            mask_q <= 1'b0;
        end else begin
            if (restart) begin
                cnt_q  <= '0;
                wave_q <= 1'b0;
            end else if (step) begin
                cnt_q <= cnt_inc;
                if (mode_q.wave) wave_q <= wave_d;
            end
            if (mode_wr) begin
                mode_q.rc_act <= wdata[19:18];
                mode_q.ra_act <= wdata[17:16];
                mode_q.wave   <= wdata[15];
                mode_q.src    <= wdata[2:0];
            end
            if (ra_wr) ra_q <= wdata[CNT_W-1:0];
            if (rb_wr) rb_q <= wdata[CNT_W-1:0];
            if (rc_wr) rc_q <= wdata[CNT_W-1:0];
            if (step && (&cnt_q)) ovf_q <= 1'b1;
            else if (sr_rd)       ovf_q <= 1'b0;
            if (ien_wr && wdata[0])       mask_q <= 1'b1;
            else if (idis_wr && wdata[0]) mask_q <= 1'b0;
        end
    end

    assign cnt_o  = cnt_q;
    assign ra_o   = ra_q;
    assign rb_o   = rb_q;
    assign rc_o   = rc_q;
    assign mode_o = mode_q;
    assign ovf_o  = ovf_q;
    assign mask_o = mask_q;
    assign wave_o = wave_q;
    assign irq_o  = ovf_q & mask_q;
    assign off_o  = (st_q == CH_OFF);
    assign run_o  = (st_q == CH_RUN);

endmodule

// File: rtl/tc_cascade.sv
module tc_cascade
    import tc_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_clk_in,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic        irq
);

    logic [5:0] ofs;
    logic       wp_q;
    logic [1:0] xmux_q;
    logic       sync_go;

    logic [CNT_W-1:0] cnt_v [NUM_CH];
    logic [CNT_W-1:0] ra_v  [NUM_CH];
    logic [CNT_W-1:0] rb_v  [NUM_CH];
    logic [CNT_W-1:0] rc_v  [NUM_CH];
    logic [31:0]      mode_w[NUM_CH];
    ch_mode_t         mode_v[NUM_CH];
    logic [NUM_CH-1:0] wave_v, ovf_v, mask_v, irq_v, off_v, run_v, xc1_v;

    assign ofs     = bus_addr[5:0];
    assign sync_go = bus_wr && (bus_addr == ADR_SYNC) && bus_wdata[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp_q   <= 1'b0;
            xmux_q <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADR_WPROT && bus_wdata[31:8] == WP_KEY) wp_q <= bus_wdata[0];
            if (bus_addr == ADR_XMUX) xmux_q <= bus_wdata[3:2];
        end
    end

    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
            logic hit, cfg_ok;
            assign hit    = (bus_addr[7:6] == 2'(k));
            assign cfg_ok = bus_wr && hit && !wp_q;

            if (k == 1) begin : g_xc1_mux
                assign xc1_v[k] = (xmux_q == XC1_FROM_CH0) & wave_v[0];
            end else begin : g_xc1_tie
                assign xc1_v[k] = 1'b0;
            end

            tc_channel #(
                .CNT_W       (CNT_W),
                .SYNC_STAGES (SYNC_STAGES)
            ) u_chan (
                .clk       (clk),
                .rst_n     (rst_n),
                .src_slow  (slow_clk_in),
                .src_xc1   (xc1_v[k]),
                .ctrl_wr   (bus_wr && hit && ofs == OFS_CTRL),
                .ctrl_bits (bus_wdata[2:0]),
                .sync_trg  (sync_go),
                .mode_wr   (cfg_ok && ofs == OFS_MODE),
                .ra_wr     (cfg_ok && ofs == OFS_RA),
                .rb_wr     (cfg_ok && ofs == OFS_RB),
                .rc_wr     (cfg_ok && ofs == OFS_RC),
                .ien_wr    (bus_wr && hit && ofs == OFS_IEN),
                .idis_wr   (bus_wr && hit && ofs == OFS_IDIS),
                .sr_rd     (bus_rd && hit && ofs == OFS_SR),
                .wdata     (bus_wdata),
                .cnt_o     (cnt_v[k]),
                .ra_o      (ra_v[k]),
                .rb_o      (rb_v[k]),
                .rc_o      (rc_v[k]),
                .mode_o    (mode_v[k]),
                .ovf_o     (ovf_v[k]),
                .mask_o    (mask_v[k]),
                .wave_o    (wave_v[k]),
                .irq_o     (irq_v[k]),
                .off_o     (off_v[k]),
                .run_o     (run_v[k])
            );

            assign mode_w[k] = mode_word(mode_v[k]);
        end
    endgenerate

    always_comb begin
        bus_rdata = '0;
        for (int k = 0; k < NUM_CH; k++) begin
            if (bus_addr[7:6] == 2'(k)) begin
                case (ofs)
                    OFS_MODE: bus_rdata = mode_w[k];
                    OFS_CV:   bus_rdata[CNT_W-1:0] = cnt_v[k];
                    OFS_RA:   bus_rdata[CNT_W-1:0] = ra_v[k];
                    OFS_RB:   bus_rdata[CNT_W-1:0] = rb_v[k];
                    OFS_RC:   bus_rdata[CNT_W-1:0] = rc_v[k];
                    OFS_SR:   bus_rdata[0] = ovf_v[k];
                    default:  bus_rdata = '0;
                endcase
            end
        end
        if (bus_addr == ADR_XMUX)  bus_rdata[3:2] = xmux_q;
        if (bus_addr == ADR_WPROT) bus_rdata[0]   = wp_q;
    end

    assign irq = |irq_v;

endmodule

// File: rtl/tc_cascade_checker.sv
module tc_cascade_checker #(
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic             sync_bit,
    input logic             wp_on,
    input logic [31:0]      mode0_word,
    input logic [CNT_W-1:0] ra0,
    input logic [CNT_W-1:0] cnt0,
    input logic [CNT_W-1:0] cnt1,
    input logic             off0,
    input logic             off1,
    input logic             run0,
    input logic [1:0]       mask_v,
    input logic             irq
);

    // R9: protected mode register keeps its value
    assert_wp_mode_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_on && bus_wr && bus_addr == 8'h04) |=> $stable(mode0_word));

    // R9: protected compare register keeps its value
    assert_wp_ra_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (wp_on && bus_wr && bus_addr == 8'h14) |=> $stable(ra0));

    // R1: a disabled channel holds unless its control register is written
    assert_off_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (off0 && !(bus_wr && bus_addr == 8'h00)) |=> $stable(cnt0));

    // R3: a running counter moves by at most one step or restarts
    assert_single_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        run0 |=> (cnt0 == $past(cnt0) || cnt0 == CNT_W'($past(cnt0) + 1'b1) || cnt0 == '0));

    // R8: sync zeroes both enabled channels together
    assert_sync_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 8'hC0 && sync_bit && !off0 && !off1) |=> (cnt0 == '0 && cnt1 == '0));

    // R5: no interrupt without a mask bit
    assert_irq_needs_mask_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (mask_v != 2'b00));

endmodule

bind tc_cascade tc_cascade_checker #(.CNT_W(CNT_W)) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .sync_bit   (bus_wdata[0]),
    .wp_on      (wp_q),
    .mode0_word (mode_w[0]),
    .ra0        (ra_v[0]),
    .cnt0       (cnt_v[0]),
    .cnt1       (cnt_v[1]),
    .off0       (off_v[0]),
    .off1       (off_v[1]),
    .run0       (run_v[0]),
    .mask_v     (mask_v),
    .irq        (irq)
);

// File: tb/tc_cascade_bench.sv
`timescale 1ns/1ps
module tc_cascade_bench;

    localparam int W = 8;
    localparam logic [7:0] C0_CTRL = 8'h00, C0_MODE = 8'h04, C0_CV = 8'h10, C0_RA = 8'h14;
    localparam logic [7:0] C0_RC = 8'h1C, C0_SR = 8'h20, C0_IEN = 8'h24, C0_IDIS = 8'h28;
    localparam logic [7:0] C1_CTRL = 8'h40, C1_MODE = 8'h44, C1_CV = 8'h50;
    localparam logic [7:0] A_SYNC = 8'hC0, A_XMUX = 8'hC4, A_WP = 8'hE4;
    localparam logic [31:0] KEY = 32'h54494D00;

    logic clk = 1'b0, rst_n = 1'b0, slow = 1'b0;
    logic bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0, bus_rdata;
    logic irq;

    int n_chk = 0, n_err = 0;
    bit done = 1'b0;

    typedef struct { logic [31:0] exp; logic [7:0] adr; string tag; } sb_item_t;
    sb_item_t sb_q[$];

    tc_cascade #(.CNT_W(W)) u_tc_cascade (
        .clk(clk), .rst_n(rst_n), .slow_clk_in(slow),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
    );

    always #4 clk = ~clk;

    // monitor: compares each scored read against the queued expectation
    always @(negedge clk) begin
        #2;
        if (bus_rd && sb_q.size() > 0) begin
            sb_item_t it;
            it = sb_q.pop_front();
            n_chk++;
            if (bus_rdata !== it.exp) begin
                n_err++;
                $display("FAIL %s addr=%02h actual=%08h expected=%08h", it.tag, it.adr, bus_rdata, it.exp);
            end
        end
    end

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk); bus_wr = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        it.exp = e; it.adr = a; it.tag = tag;
        sb_q.push_back(it);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic rd_raw(input logic [7:0] a, output logic [31:0] v);
        @(negedge clk); bus_addr = a; bus_rd = 1'b1;
        #2 v = bus_rdata;
        @(negedge clk); bus_rd = 1'b0;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) begin
            @(negedge clk) slow = 1'b1;
            @(negedge clk) slow = 1'b0;
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic read_wide(output logic [63:0] v);
        logic [31:0] hi_a, lo, hi_b;
        int tries = 0;
        do begin
            rd_raw(C1_CV, hi_a);
            rd_raw(C0_CV, lo);
            rd_raw(C1_CV, hi_b);
            tries++;
        end while (hi_a != hi_b && tries < 8);
        v = (64'(hi_b) << W) | 64'(lo);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [63:0] wide;
        int ref_ticks;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd_chk(C0_MODE, 32'h0, "R1 reset mode");
        rd_chk(C0_CV,   32'h0, "R1 reset count");
        rd_chk(C0_SR,   32'h0, "R1 reset status");
        rd_chk(A_WP,    32'h0, "R1 reset protection");
        rd_chk(A_XMUX,  32'h0, "R1 reset routing");
        chk("R1 reset irq", 64'(irq), 64'd0);

        // R1 armed holds, R2 trigger starts, R3 counts slow clock
        wr(C0_MODE, 32'h4);
        wr(C0_CTRL, 32'h1);
        tick(3);
        rd_chk(C0_CV, 32'd0, "R1 armed holds");
        wr(C0_CTRL, 32'h4);
        tick(5);
        rd_chk(C0_CV, 32'd5, "R3 counts slow edges");

        // R3 no-clock source selection
        wr(C0_MODE, 32'h0);
        tick(2);
        rd_chk(C0_CV, 32'd5, "R3 no source no count");
        wr(C0_MODE, 32'h4);

        // R1 disable, R2 trigger ignored while off
        wr(C0_CTRL, 32'h2);
        tick(3);
        rd_chk(C0_CV, 32'd5, "R1 disabled holds");
        wr(C0_CTRL, 32'h4);
        rd_chk(C0_CV, 32'd5, "R2 trigger ignored when off");
        wr(C0_CTRL, 32'h5);
        rd_chk(C0_CV, 32'd0, "R2 enable plus trigger restarts");
        tick(2);
        rd_chk(C0_CV, 32'd2, "R3 counts after restart");

        // R4 overflow and R5 interrupt mask
        wr(C0_IEN, 32'h1);
        tick(254);
        rd_chk(C0_CV, 32'd0, "R3 wrap to zero");
        chk("R5 irq on masked-in overflow", 64'(irq), 64'd1);
        rd_chk(C0_SR, 32'h1, "R4 overflow flag");
        rd_chk(C0_SR, 32'h0, "R4 cleared by read");
        chk("R5 irq drops after clear", 64'(irq), 64'd0);
        wr(C0_IDIS, 32'h1);
        tick(256);
        chk("R5 irq masked", 64'(irq), 64'd0);
        rd_chk(C0_SR, 32'h1, "R4 flag set while masked");

        // R7 routing off: channel 1 sees no clock
        wr(C1_MODE, 32'h8006);
        wr(C1_CTRL, 32'h1);
        wr(C0_MODE, 32'h0009_8004);
        wr(C0_RA, 32'h1);
        wr(C0_RC, 32'h80);
        wr(A_SYNC, 32'h1);
        tick(3);
        rd_chk(C1_CV, 32'd0, "R7 unrouted XC1 idle");
        rd_chk(C0_CV, 32'd3, "R8 channel 0 runs after sync");

        // R7 routing on, R8 sync, R6 set/clear actions
        wr(A_XMUX, 32'h8);
        rd_chk(A_XMUX, 32'h8, "R7 routing readback");
        repeat (6) @(negedge clk);
        wr(A_SYNC, 32'h1);
        rd_chk(C0_CV, 32'd0, "R8 sync clears channel 0");
        rd_chk(C1_CV, 32'd0, "R8 sync clears channel 1");
        tick(1);
        rd_chk(C1_CV, 32'd1, "R6 set at RA match");
        tick(255);
        rd_chk(C1_CV, 32'd1, "R6 cleared at RC, no edge at wrap");
        tick(1);
        rd_chk(C1_CV, 32'd2, "R6 next epoch edge");

        // R6 toggle action
        wr(C0_MODE, 32'h0003_8004);
        wr(A_SYNC, 32'h1);
        tick(1);
        rd_chk(C1_CV, 32'd1, "R6 toggle high");
        tick(256);
        rd_chk(C1_CV, 32'd1, "R6 toggle low");
        tick(256);
        rd_chk(C1_CV, 32'd2, "R6 toggle high again");

        // R9 write protection
        wr(A_WP, KEY | 32'h1);
        rd_chk(A_WP, 32'h1, "R9 protection on");
        wr(C0_RA, 32'h5);
        rd_chk(C0_RA, 32'h1, "R9 RA write ignored");
        wr(C0_MODE, 32'h0);
        rd_chk(C0_MODE, 32'h0003_8004, "R9 mode write ignored");
        wr(A_WP, 32'h1234_5600);
        rd_chk(A_WP, 32'h1, "R9 wrong key ignored");
        wr(A_WP, KEY);
        rd_chk(A_WP, 32'h0, "R9 protection off");
        wr(C0_RA, 32'h5);
        rd_chk(C0_RA, 32'h5, "R9 RA write accepted");

        // R10 wide count through the retry read
        wr(C0_MODE, 32'h0009_8004);
        wr(C0_RA, 32'h0);
        wr(C0_RC, 32'h80);
        wr(A_SYNC, 32'h1);
        ref_ticks = 805;
        tick(805);
        read_wide(wide);
        chk("R10 wide count 805", wide, 64'(ref_ticks));
        tick(300);
        ref_ticks += 300;
        read_wide(wide);
        chk("R10 wide count 1105", wide, 64'(ref_ticks));

        repeat (4) @(negedge clk);
        if (sb_q.size() != 0) chk("scoreboard drained", 64'(sb_q.size()), 64'd0);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

endmodule